// File: doc/BRIEF.md
# Fixed-Point to Floating-Point Converter

This block turns a signed two's complement fixed-point word into a binary floating-point word in a single combinational pass. The fixed-point format is set by two parameters: the total width and the number of fraction bits below the binary point. The floating-point format is set by the exponent and mantissa widths, and the float word width follows from them. The defaults give a 32-bit input with 20 fraction bits and a single-precision result.

The datapath has three stages. It splits off the sign and forms the unsigned magnitude. A priority encoder then finds the highest set bit of that magnitude. The magnitude is shifted left so that this bit reaches the top. The bit position, corrected by the binary point and the exponent bias, becomes the exponent. The bits below the leading one become the stored fraction, and the leading one itself is dropped as the hidden bit. Low-order bits that do not fit in the mantissa are discarded without rounding. A zero input gives positive zero. Because a fixed-point value is always finite, the exponent field never reaches its all-ones code.

Top module: `fx2fl_conv`

## Requirements
- R1: An all-zero input yields an all-zero output word (sign 0, exponent 0, fraction 0). Negative zero is never produced.
- R2: The output sign bit (bit FLT_W-1) equals the most significant bit of the input.
- R3: A negative input converts to the same exponent and fraction as its two's complement magnitude, with the sign bit set.
- R4: For a nonzero input, the exponent field (bits FLT_W-2 down to MAN_W) equals p - FRAC_W + (2^(EXP_W-1) - 1), where p is the index of the highest set bit of the magnitude. With the defaults this is p + 107.
- R5: The fraction field (bits MAN_W-1 down to 0) holds the magnitude bits directly below the leading one, left-aligned. Bits below the mantissa width are truncated, and missing low bits are filled with zero.
- R6: The most negative input (only the top bit set) converts as the magnitude 2^(FIX_W-1). With the defaults the result is sign 1, exponent 138, fraction 0.
- R7: The exponent field is never all ones, for any input.
- R8: An input of 1 (the smallest positive step) yields sign 0, exponent 2^(EXP_W-1)-1-FRAC_W (107 with the defaults), and fraction 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fix_i | input | FIX_W | Signed two's complement fixed-point value with FRAC_W fraction bits |
| flt_o | output | FLT_W | Floating-point result: sign, biased exponent, fraction |

## Verification
Fixed corner values cover the following cases:
- Zero, which separates the positive-zero rule from the normal path.
- The smallest step and the most negative value, which test the two ends of the encoder range and the unsigned treatment of the magnitude.
- Mirrored positive/negative pairs, which show that only the sign bit differs between them.

Random full-width words exercise truncation of the low bits. Random words shifted down to a few significant bits exercise every leading-one position and the zero-filled fraction tail. Each result is compared with a reference that goes through the simulator's real-number arithmetic, so it shares no logic with the shifter or the encoder.

// File: rtl/fx2fl_pkg.sv
package fx2fl_pkg;
  function automatic int bias_of(int exp_w);
    return (1 << (exp_w - 1)) - 1;
  endfunction
endpackage

// File: rtl/fx2fl_sign_mag.sv
module fx2fl_sign_mag #(
  parameter int FIX_W = 32
) (
  input  logic [FIX_W-1:0] fix_i,
  output logic             neg_o,
  output logic [FIX_W-1:0] mag_o
);
  assign neg_o = fix_i[FIX_W-1];
  // the most negative value maps onto itself, which is correct read as unsigned
  assign mag_o = neg_o ? (~fix_i + FIX_W'(1)) : fix_i;

  always_comb begin
    a_r3_mag_nonzero: assert (fix_i == '0 || mag_o != '0);
    a_r6_top_only: assert (!(neg_o && fix_i[FIX_W-2:0] == '0) || mag_o == fix_i);
  end
endmodule

// File: rtl/fx2fl_lead_one.sv
module fx2fl_lead_one #(
  parameter int W     = 32,
  parameter int POS_W = 5
) (
  input  logic [W-1:0]     vec_i,
  output logic [POS_W-1:0] pos_o,
  output logic             hit_o
);
  always_comb begin
    pos_o = '0;
    hit_o = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) begin
        pos_o = POS_W'(i);
        hit_o = 1'b1;
      end
    end
  end

  always_comb begin
    a_r4_pos_is_set: assert (!hit_o || vec_i[pos_o]);
    a_r4_none_above: assert (!hit_o || (vec_i >> pos_o) == W'(1));
    a_r1_miss_on_zero: assert (hit_o || vec_i == '0);
  end
endmodule

// File: rtl/fx2fl_norm_pack.sv
module fx2fl_norm_pack
  import fx2fl_pkg::*;
#(
  parameter int FIX_W  = 32,
  parameter int FRAC_W = 20,
  parameter int EXP_W  = 8,
  parameter int MAN_W  = 23,
  parameter int POS_W  = 5
) (
  input  logic [FIX_W-1:0] mag_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic             hit_i,
  output logic [EXP_W-1:0] exp_o,
  output logic [MAN_W-1:0] man_o
);
  localparam int EXP_OFS = bias_of(EXP_W) - FRAC_W;

  logic [POS_W-1:0] shamt;
  logic [FIX_W-1:0] norm;
  logic [31:0]      exp_full;

  assign shamt    = POS_W'(FIX_W - 1) - pos_i;
  assign norm     = mag_i << shamt;
  assign exp_full = 32'(pos_i) + 32'(EXP_OFS);
  assign exp_o    = hit_i ? exp_full[EXP_W-1:0] : '0;

  generate
    if (FIX_W - 1 >= MAN_W) begin : g_trunc
      assign man_o = norm[FIX_W-2 -: MAN_W];
    end else begin : g_pad
      assign man_o = {norm[FIX_W-2:0], {(MAN_W - FIX_W + 1){1'b0}}};
    end
  endgenerate

  always_comb begin
    a_r5_top_aligned: assert (!hit_i || norm[FIX_W-1]);
    a_r7_not_special: assert (exp_o != '1);
    a_r1_zero_fields: assert (hit_i || (exp_o == '0 && man_o == '0));
  end
endmodule

// File: rtl/fx2fl_conv.sv
module fx2fl_conv #(
  parameter int FIX_W  = 32,
  parameter int FRAC_W = 20,
  parameter int EXP_W  = 8,
  parameter int MAN_W  = 23,
  localparam int FLT_W = 1 + EXP_W + MAN_W
) (
  input  logic [FIX_W-1:0] fix_i,
  output logic [FLT_W-1:0] flt_o
);
  localparam int POS_W = (FIX_W > 2) ? $clog2(FIX_W) : 1;

  logic             neg;
  logic [FIX_W-1:0] mag;
  logic [POS_W-1:0] pos;
  logic             hit;
  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;

  fx2fl_sign_mag #(.FIX_W(FIX_W)) u_sign_mag (
    .fix_i(fix_i), .neg_o(neg), .mag_o(mag)
  );

  fx2fl_lead_one #(.W(FIX_W), .POS_W(POS_W)) u_lead_one (
    .vec_i(mag), .pos_o(pos), .hit_o(hit)
  );

  fx2fl_norm_pack #(
    .FIX_W(FIX_W), .FRAC_W(FRAC_W), .EXP_W(EXP_W), .MAN_W(MAN_W), .POS_W(POS_W)
  ) u_norm_pack (
    .mag_i(mag), .pos_i(pos), .hit_i(hit), .exp_o(exp_f), .man_o(man_f)
  );

  assign flt_o = {neg, exp_f, man_f};

  always_comb begin
    a_r1_pos_zero: assert (fix_i != '0 || flt_o == '0);
    a_r7_finite_out: assert (flt_o[FLT_W-2 -: EXP_W] != '1);
  end
endmodule

// File: tb/fx2fl_conv_tb.sv
`timescale 1ns/1ps
module fx2fl_conv_tb_top;
  logic        clk = 1'b0;
  logic [31:0] fix;
  logic [31:0] flt;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  fx2fl_conv dut_i (.fix_i(fix), .flt_o(flt));

  // reference via simulator real arithmetic, truncated to single precision
  function automatic logic [31:0] ref_f(logic [31:0] x);
    real r;
    logic [63:0] d;
    if (x == 32'd0) return 32'd0;
    r = $itor($signed(x)) / 1048576.0;
    d = $realtobits(r);
    return {d[63], 8'(int'(d[62:52]) - 1023 + 127), d[51:29]};
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s fix=%h got=%h expected=%h", req, fix, got, exp);
    end
  endtask

  task automatic apply(logic [31:0] v);
    @(posedge clk);
    fix = v;
    @(negedge clk);
  endtask

  task automatic full(logic [31:0] v);
    logic [31:0] e;
    apply(v);
    e = ref_f(v);
    chk("R2 sign", {31'd0, flt[31]}, {31'd0, v[31]});
    chk("R4 exponent", {24'd0, flt[30:23]}, {24'd0, e[30:23]});
    chk("R5 fraction", {9'd0, flt[22:0]}, {9'd0, e[22:0]});
    checks++;
    if (flt[30:23] == 8'hFF) begin
      fails++;
      $display("FAIL R7 fix=%h got=%h expected=exp!=ff", v, flt);
    end
  endtask

  initial begin
    logic [31:0] pos_res;
    void'($urandom(32'h5EED_0042));
    fix = 32'd0;
    @(negedge clk);
    chk("R1 zero at start", flt, 32'h0000_0000);

    apply(32'd0);
    chk("R1 zero", flt, 32'h0000_0000);
    apply(32'd1);
    chk("R8 lsb", flt, {1'b0, 8'd107, 23'd0});
    apply(32'h8000_0000);
    chk("R6 most negative", flt, {1'b1, 8'd138, 23'd0});
    apply(32'h0010_0000);
    chk("R4 one", flt, 32'h3F80_0000);
    apply(32'hFFF0_0000);
    chk("R3 minus one", flt, 32'hBF80_0000);
    apply(32'h7FFF_FFFF);
    chk("R5 truncation", flt, {1'b0, 8'd137, 23'h7F_FFFF});
    apply(32'hFFFF_FFFF);
    chk("R3 minus lsb", flt, {1'b1, 8'd107, 23'd0});
    apply(32'h0018_0000);
    chk("R5 one and half", flt, 32'h3FC0_0000);

    for (int i = 0; i < 600; i++) begin
      logic [31:0] v;
      v = $urandom();
      full(v);
      pos_res = flt;
      if (v[31] && v != 32'h8000_0000) begin
        apply(~v + 32'd1);
        chk("R3 mirror", {1'b1, flt[30:0]}, pos_res);
      end
    end
    for (int i = 0; i < 600; i++) begin
      logic [31:0] v;
      v = $urandom() >> ($urandom() % 32);
      if ($urandom() % 2 == 1) v = ~v + 32'd1;
      full(v);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired got=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule